// File: doc/BRIEF.md
# Sleep and Supply Fault Supervisor

This block decides, at device level, whether the output bridges may drive and whether the rest of the logic must be held in reset. It watches an active-low sleep request and two supply-level conditions from the sensing circuits: a supply-low flag and a die over-temperature flag. A separate input marks when the temperature has cooled past the release point. The block drives one global bridge enable, a synchronous logic-reset request to the neighbouring blocks, and an over-temperature request that is merged into the shared open-drain fault pin.

The three conditions are handled under different policies. A sleep request is honoured only after a fixed entry delay. Once asleep, the logic is reset and the other inputs have no effect. On wake, the bridges stay off for a fixed wake delay. A low supply acts at once: it resets everything and never reports a fault. Release from a low supply goes through the same wake delay. An over-temperature event turns the bridges off and reports a fault, but the logic keeps running. The fault is released one cycle after the bridges are back on. Supply-low takes precedence over sleep, and sleep takes precedence over over-temperature.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, bridge_en_o is 0, logic_rst_o is 1 and ot_fault_o is 0.
- R2: When sleep_ni is sampled low on an operating edge, bridge_en_o stays 1 for exactly T_SLEEP further cycles and goes to 0 after that. If sleep_ni returns high before T_SLEEP low samples, the bridges are never disabled.
- R3: Once asleep, bridge_en_o is 0 and logic_rst_o is 1. An over-temperature trip during sleep neither raises ot_fault_o nor leaves a fault behind after wake.
- R4: On the edge that samples sleep_ni high again, logic_rst_o falls. bridge_en_o stays 0 for T_WAKE cycles and rises on the following one.
- R5: A high uv_i disables the bridges and asserts logic_rst_o on the next cycle, regardless of sleep_ni or the thermal state. When uv_i is released, the block goes to sleep if sleep_ni is low; otherwise it passes through the T_WAKE delay of R4.
- R6: ot_fault_o is never 1 while logic_rst_o is 1. A supply-low event discards any pending thermal fault.
- R7: An ot_trip_i sampled while operating clears bridge_en_o on the next cycle and sets ot_fault_o one cycle later. logic_rst_o stays 0.
- R8: A thermal fault persists after ot_trip_i falls, until ot_clear_i is sampled high. bridge_en_o returns on the next cycle, and ot_fault_o falls one cycle after that.
- R9: A sleep request made during a thermal fault still completes after T_SLEEP cycles. Entering sleep then drops the thermal fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_ni | input | 1 | Sleep request, active low |
| uv_i | input | 1 | Supply below threshold, synchronous |
| ot_trip_i | input | 1 | Die temperature above trip point, synchronous |
| ot_clear_i | input | 1 | Die temperature below trip point minus hysteresis |
| bridge_en_o | output | 1 | Global bridge enable |
| logic_rst_o | output | 1 | Synchronous reset request to the other blocks |
| ot_fault_o | output | 1 | Over-temperature fault request to the fault pin |

## Verification
Any wrong mode in the sequencer appears on bridge_en_o or logic_rst_o within one cycle. A miscounted entry or wake delay shifts the edge of bridge_en_o by that many cycles, so each delay is checked on the exact cycle on both sides of the edge. A thermal latch that is cleared too early, or not cleared, shows up on ot_fault_o two cycles after the offending input, or on the cycle after wake. A supply-low event that leaks a fault is visible on its first cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_DOWN  = 3'd0,  // supply low or power-on: everything held
    M_RUN   = 3'd1,
    M_ENTER = 3'd2,  // sleep requested, delay running
    M_SLEEP = 3'd3,
    M_WAKE  = 3'd4   // wake delay running, logic live, bridges off
  } mode_e;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int unsigned T_SLEEP = 8,
  parameter int unsigned T_WAKE  = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_ni,
  input  logic  uv_i,
  output mode_e mode_o
);
  localparam int unsigned MAX_T = (T_SLEEP > T_WAKE) ? T_SLEEP : T_WAKE;
  localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);
  localparam logic [CNT_W-1:0] SLP_LAST = CNT_W'(T_SLEEP - 1);
  localparam logic [CNT_W-1:0] WAK_LAST = CNT_W'(T_WAKE - 1);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_DOWN;
      cnt_q  <= '0;
    end else if (uv_i) begin
      mode_q <= M_DOWN;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        M_DOWN: begin
          cnt_q  <= '0;
          mode_q <= sleep_ni ? M_WAKE : M_SLEEP;
        end
        M_RUN: begin
          cnt_q <= '0;
          if (!sleep_ni) mode_q <= M_ENTER;
        end
        M_ENTER: begin
          if (sleep_ni) begin
            mode_q <= M_RUN;
            cnt_q  <= '0;
          end else if (cnt_q == SLP_LAST) begin
            mode_q <= M_SLEEP;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        M_SLEEP: begin
          cnt_q <= '0;
          if (sleep_ni) mode_q <= M_WAKE;
        end
        M_WAKE: begin
          if (!sleep_ni) begin
            mode_q <= M_SLEEP;
            cnt_q  <= '0;
          end else if (cnt_q == WAK_LAST) begin
            mode_q <= M_RUN;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          mode_q <= M_DOWN;
          cnt_q  <= '0;
        end
      endcase
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pmc_thermal.sv
module pmc_thermal
  import pmc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  uv_i,
  input  logic  trip_i,
  input  logic  clear_i,
  output logic  hold_o,
  output logic  fault_o
);
  logic hold_q, fault_q, wipe;

  // internal logic reset: supply low now, or already held in reset
  assign wipe = uv_i || (mode_i == M_DOWN) || (mode_i == M_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (wipe)         hold_q <= 1'b0;
      else if (trip_i)  hold_q <= 1'b1;
      else if (clear_i) hold_q <= 1'b0;
      // report lags the bridge decision by one cycle in both directions
      fault_q <= wipe ? 1'b0 : hold_q;
    end
  end

  assign hold_o  = hold_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned T_SLEEP = 8,
  parameter int unsigned T_WAKE  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_ni,
  input  logic uv_i,
  input  logic ot_trip_i,
  input  logic ot_clear_i,
  output logic bridge_en_o,
  output logic logic_rst_o,
  output logic ot_fault_o
);
  mode_e mode;
  logic  ot_hold, ot_fault_raw;

  pmc_seq #(.T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_ni (sleep_ni),
    .uv_i     (uv_i),
    .mode_o   (mode)
  );

  pmc_thermal u_thermal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .uv_i    (uv_i),
    .trip_i  (ot_trip_i),
    .clear_i (ot_clear_i),
    .hold_o  (ot_hold),
    .fault_o (ot_fault_raw)
  );

  assign logic_rst_o = (mode == M_DOWN) || (mode == M_SLEEP);
  assign bridge_en_o = ((mode == M_RUN) || (mode == M_ENTER)) && !ot_hold;
  assign ot_fault_o  = ot_fault_raw && !logic_rst_o;
endmodule

// File: rtl/pwr_mode_ctrl_sva.sv
module pwr_mode_ctrl_sva #(
  parameter int unsigned T_SLEEP = 8,
  parameter int unsigned T_WAKE  = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_ni,
  input logic uv_i,
  input logic ot_trip_i,
  input logic ot_clear_i,
  input logic bridge_en_o,
  input logic logic_rst_o,
  input logic ot_fault_o
);
  localparam logic [31:0] SAT = 32'hFFFF;
  logic [31:0] low_run, high_run;

  // consecutive sampled cycles of sleep request / of wake conditions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      if (sleep_ni || uv_i)   low_run <= '0;
      else if (low_run < SAT) low_run <= low_run + 1;
      if (!sleep_ni || uv_i)   high_run <= '0;
      else if (high_run < SAT) high_run <= high_run + 1;
    end
  end

  p_uv_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (!bridge_en_o && logic_rst_o));

  p_uv_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> !ot_fault_o);

  p_reset_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> !bridge_en_o);

  p_wake_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bridge_en_o) |-> (high_run >= T_WAKE));

  p_sleep_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bridge_en_o) && !$past(uv_i) && !$past(ot_trip_i)) |-> (low_run >= T_SLEEP));

  p_trip_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ot_fault_o) |-> !bridge_en_o);

  p_release_after_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ot_fault_o) && !logic_rst_o) |-> $past(bridge_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_sva #(.T_SLEEP(T_SLEEP), .T_WAKE(T_WAKE)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_ni    (sleep_ni),
  .uv_i        (uv_i),
  .ot_trip_i   (ot_trip_i),
  .ot_clear_i  (ot_clear_i),
  .bridge_en_o (bridge_en_o),
  .logic_rst_o (logic_rst_o),
  .ot_fault_o  (ot_fault_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int unsigned TS = 8;
  localparam int unsigned TW = 16;

  logic clk = 1'b0;
  logic rst_n, sleep_n, uv, trip, clr;
  logic bridge_en, logic_rst, ot_fault;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.T_SLEEP(TS), .T_WAKE(TW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sleep_ni    (sleep_n),
    .uv_i        (uv),
    .ot_trip_i   (trip),
    .ot_clear_i  (clr),
    .bridge_en_o (bridge_en),
    .logic_rst_o (logic_rst),
    .ot_fault_o  (ot_fault)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    chk("R1 bridge in reset", bridge_en, 1'b0);
    chk("R1 logic_rst in reset", logic_rst, 1'b1);
    chk("R1 fault in reset", ot_fault, 1'b0);
    rst_n = 1'b1;
    step(TW);
    chk("R4 logic live during wake", logic_rst, 1'b0);
    chk("R4 bridge held last wake cycle", bridge_en, 1'b0);
    step(1);
    chk("R4 bridge on after wake", bridge_en, 1'b1);
  endtask

  task automatic t_sleep_abort;
    sleep_n = 1'b0;
    for (int i = 1; i < TS; i++) begin
      step(1);
      chk("R2 bridge kept during entry", bridge_en, 1'b1);
    end
    sleep_n = 1'b1;
    step(2);
    chk("R2 aborted entry keeps bridge", bridge_en, 1'b1);
    chk("R2 aborted entry no reset", logic_rst, 1'b0);
  endtask

  task automatic t_sleep_full;
    sleep_n = 1'b0;
    step(TS);
    chk("R2 bridge on last entry cycle", bridge_en, 1'b1);
    step(1);
    chk("R2 bridge off after entry", bridge_en, 1'b0);
    chk("R3 logic reset in sleep", logic_rst, 1'b1);
    trip = 1'b1;
    step(3);
    chk("R3 trip ignored in sleep", ot_fault, 1'b0);
    trip = 1'b0;
    sleep_n = 1'b1;
    step(1);
    chk("R4 reset drops first wake cycle", logic_rst, 1'b0);
    step(TW - 1);
    chk("R4 bridge held through wake", bridge_en, 1'b0);
    step(1);
    chk("R4 bridge on after wake", bridge_en, 1'b1);
    chk("R3 no fault left after sleep", ot_fault, 1'b0);
  endtask

  task automatic t_thermal;
    trip = 1'b1;
    step(1);
    chk("R7 bridge off on trip", bridge_en, 1'b0);
    chk("R7 fault lags bridge", ot_fault, 1'b0);
    chk("R7 logic keeps running", logic_rst, 1'b0);
    step(1);
    chk("R7 fault reported", ot_fault, 1'b1);
    trip = 1'b0;
    step(5);
    chk("R8 bridge off until clear", bridge_en, 1'b0);
    chk("R8 fault held until clear", ot_fault, 1'b1);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk("R8 bridge back after clear", bridge_en, 1'b1);
    chk("R8 fault still out while resuming", ot_fault, 1'b1);
    step(1);
    chk("R8 fault released after resume", ot_fault, 1'b0);
  endtask

  task automatic t_uv_run;
    trip = 1'b1;
    step(2);
    chk("R7 fault before supply loss", ot_fault, 1'b1);
    uv = 1'b1;
    step(1);
    chk("R5 bridge off on supply loss", bridge_en, 1'b0);
    chk("R5 logic reset on supply loss", logic_rst, 1'b1);
    chk("R6 no fault on supply loss", ot_fault, 1'b0);
    trip = 1'b0;
    sleep_n = 1'b0;
    step(3);
    chk("R5 supply loss over sleep", logic_rst, 1'b1);
    chk("R6 fault stays low", ot_fault, 1'b0);
    sleep_n = 1'b1;
    uv = 1'b0;
    step(TW);
    chk("R5 wake delay after supply", bridge_en, 1'b0);
    chk("R5 logic live after supply", logic_rst, 1'b0);
    step(1);
    chk("R5 bridge on after supply wake", bridge_en, 1'b1);
    chk("R6 thermal discarded by supply loss", ot_fault, 1'b0);
  endtask

  task automatic t_uv_to_sleep;
    uv = 1'b1;
    step(1);
    sleep_n = 1'b0;
    uv = 1'b0;
    step(1);
    chk("R5 supply release into sleep reset", logic_rst, 1'b1);
    chk("R5 supply release into sleep bridge", bridge_en, 1'b0);
    sleep_n = 1'b1;
    step(TW);
    chk("R4 wake delay from sleep", bridge_en, 1'b0);
    step(1);
    chk("R4 bridge on after sleep wake", bridge_en, 1'b1);
  endtask

  task automatic t_sleep_over_thermal;
    trip = 1'b1;
    step(2);
    chk("R9 fault before sleep", ot_fault, 1'b1);
    sleep_n = 1'b0;
    step(TS);
    chk("R9 fault held during entry", ot_fault, 1'b1);
    chk("R9 bridge off during entry", bridge_en, 1'b0);
    step(1);
    chk("R9 sleep reached", logic_rst, 1'b1);
    chk("R9 fault dropped by sleep", ot_fault, 1'b0);
    trip = 1'b0;
    sleep_n = 1'b1;
    step(TW + 1);
    chk("R9 bridge on after wake", bridge_en, 1'b1);
    chk("R9 no fault after wake", ot_fault, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; sleep_n = 1'b1; uv = 1'b0; trip = 1'b0; clr = 1'b0;
    step(3);
    t_reset();
    t_sleep_abort();
    t_sleep_full();
    t_thermal();
    t_uv_run();
    t_uv_to_sleep();
    t_sleep_over_thermal();
    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule